// File: doc/BRIEF.md
# Synchronous RAM with Resettable Read Data

This block is a single-clock RAM with one write port and one registered read port. The read data output acts like an ordinary flip-flop that has a power-up value and a reset value. The storage array stays plain and has no reset. Its output register has no reset either. A one-bit state machine and an output multiplexer produce the configured value in its place.

At power-up, and whenever reset acts, the state machine enters `ST_FORCED`. In that state the multiplexer drives the parameter `INIT_VAL` onto `rdata`. The first clock edge that has `re` high and no reset acting takes transition `T_READ` into `ST_LIVE`. From then on `rdata` shows the registered array output. Transition `T_RESET` returns the machine to `ST_FORCED` from either state. `T_RESET` is synchronous or asynchronous according to `ASYNC_RST`, and it is removed entirely when `RESETLESS` is set. The power-up entry `T_PWRUP` comes from the state register's initial value.

Reset never touches the array contents. The block has only a synchronous read port, and it gives no combinational read path.

Top module: `rst_read_ram`

## Requirements
- R1: Once power is applied and before any clock edge or read, `rdata` equals `INIT_VAL`.
- R2: With `RESETLESS`=0 and `ASYNC_RST`=0, a clock edge that samples `rst` high makes `rdata` equal `INIT_VAL` right after that edge. The value stays there until a read completes.
- R3: A clock edge with `re`=1 and no reset acting updates `rdata` to the array word at `raddr`, one edge of latency. This holds for the first read after power-up or reset as well.
- R4: A clock edge with `re`=0 leaves `rdata` unchanged. This includes the case where `rdata` is showing `INIT_VAL`.
- R5: A write and a read to the same address on the same edge return the word stored before that write (read-first).
- R6: A reset and a read on the same edge give `INIT_VAL`, because reset takes priority.
- R7: With `RESETLESS`=1, `rst` has no effect on `rdata`. Reads continue during reset, and only the power-up value applies.
- R8: Reset does not alter the array. Words written before a reset read back unchanged afterwards.
- R9: With `ASYNC_RST`=1, `rdata` becomes `INIT_VAL` as soon as `rst` rises, without waiting for a clock edge.
- R10: An edge with `we`=1 stores `wdata` at `waddr`. Writing alone never changes `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the array, the read register and the state machine |
| rst | input | 1 | Active-high reset of the read data; synchronous or asynchronous according to `ASYNC_RST` |
| we | input | 1 | Write enable |
| waddr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| re | input | 1 | Read enable |
| raddr | input | ADDR_W | Read address |
| rdata | output | DATA_W | Registered read data, or `INIT_VAL` while in `ST_FORCED` |

## Verification
The bench builds three instances at 8-bit data and depth 8, and all three share one stimulus stream:
- **Default instance.** It uses init 13 with synchronous reset.
- **Reset-less instance.** It sets `RESETLESS`=1 and otherwise matches the default instance.
- **Asynchronous instance.** It sets `ASYNC_RST`=1 with init 0xA5.

Because the depth is small, the bench can write and read every address, and it can run a read-first pass over the whole array. A single reset pulse, applied while a read is pending, shows the three reset variants side by side. It shows the mid-cycle response of the asynchronous instance, the edge response of the synchronous instance, and the reset-less instance carrying on with the read.

// File: rtl/rst_read_ram_pkg.sv
package rst_read_ram_pkg;

    typedef enum logic {
        ST_FORCED = 1'b0,
        ST_LIVE   = 1'b1
    } rd_state_e;

endpackage

// File: rtl/rst_read_ram_array.sv
module rst_read_ram_array #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rd_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage and output register carry no reset; read-first on collision (R5).
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rd_q <= mem[raddr];
        end
    end

endmodule

// File: rtl/rst_read_ram_fsm.sv
module rst_read_ram_fsm
    import rst_read_ram_pkg::*;
#(
    parameter bit RESETLESS = 1'b0,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic re,
    output logic forced
);

    // T_PWRUP: the register starts in ST_FORCED.
    rd_state_e state = ST_FORCED;
    rd_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FORCED: state_nxt = re ? ST_LIVE : ST_FORCED; // T_READ
            ST_LIVE:   state_nxt = ST_LIVE;
            default:   state_nxt = ST_FORCED;
        endcase
    end

    generate
        if (RESETLESS) begin : g_noreset
            always_ff @(posedge clk) begin
                state <= state_nxt;
            end
        end else if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    state <= ST_FORCED;                        // T_RESET
                end else begin
                    state <= state_nxt;
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    state <= ST_FORCED;                        // T_RESET
                end else begin
                    state <= state_nxt;
                end
            end
        end
    endgenerate

    always_comb begin
        forced = (state == ST_FORCED);
    end

endmodule

// File: rtl/rst_read_ram_omux.sv
module rst_read_ram_omux #(
    parameter int unsigned       DATA_W = 8,
    parameter logic [DATA_W-1:0] INIT_W = '0
) (
    input  logic              forced,
    input  logic [DATA_W-1:0] rd_q,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = forced ? INIT_W : rd_q;
    end

endmodule

// File: rtl/rst_read_ram.sv
module rst_read_ram #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned INIT_VAL  = 13,
    parameter bit          RESETLESS = 1'b0,
    parameter bit          ASYNC_RST = 1'b0,
    localparam int unsigned ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] INIT_W = INIT_VAL[DATA_W-1:0];

    logic [DATA_W-1:0] rd_q;
    logic              forced;

    rst_read_ram_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .re    (re),
        .raddr (raddr),
        .rd_q  (rd_q)
    );

    rst_read_ram_fsm #(
        .RESETLESS (RESETLESS),
        .ASYNC_RST (ASYNC_RST)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .re     (re),
        .forced (forced)
    );

    rst_read_ram_omux #(
        .DATA_W (DATA_W),
        .INIT_W (INIT_W)
    ) u_omux (
        .forced (forced),
        .rd_q   (rd_q),
        .rdata  (rdata)
    );

endmodule

// File: rtl/rst_read_ram_chk.sv
module rst_read_ram_chk #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned INIT_VAL  = 13,
    parameter bit          RESETLESS = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              re,
    input logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] INIT_W = INIT_VAL[DATA_W-1:0];

    logic started = 1'b0;
    always_ff @(posedge clk) begin
        started <= 1'b1;
    end

    // R2 / R6: an edge with reset sampled gives the init value.
    a_r2_reset_gives_init: assert property (@(posedge clk) disable iff (rst)
        (started && !RESETLESS && $past(rst)) |-> (rdata == INIT_W));

    // R4: no read and no reset on the last edge -> output held.
    a_r4_hold_without_read: assert property (@(posedge clk) disable iff (rst && !RESETLESS)
        (started && !$past(re) && (RESETLESS || !$past(rst))) |-> $stable(rdata));

    // R3: the output only moves after a read or a reset.
    a_r3_change_only_on_read: assert property (@(posedge clk) disable iff (rst && !RESETLESS)
        (started && !$stable(rdata)) |-> ($past(re) || (!RESETLESS && $past(rst))));

    // R7: in reset-less mode a reset edge without read leaves the output alone.
    a_r7_resetless_ignores_rst: assert property (@(posedge clk)
        disable iff (rst && !RESETLESS)
        (started && RESETLESS && $past(rst) && !$past(re)) |-> $stable(rdata));

endmodule

bind rst_read_ram rst_read_ram_chk #(
    .DATA_W    (DATA_W),
    .INIT_VAL  (INIT_VAL),
    .RESETLESS (RESETLESS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .re    (re),
    .rdata (rdata)
);

// File: tb/rst_read_ram_bench.sv
module rst_read_ram_bench;

    localparam int DW = 8;
    localparam int DP = 8;
    localparam int AW = 3;
    localparam logic [DW-1:0] INIT_A = 8'd13;
    localparam logic [DW-1:0] INIT_C = 8'hA5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we = 1'b0;
    logic [AW-1:0] waddr = '0;
    logic [DW-1:0] wdata = '0;
    logic          re = 1'b0;
    logic [AW-1:0] raddr = '0;
    logic [DW-1:0] rd_a, rd_b, rd_c;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [DP];

    always #2 clk = ~clk;

    rst_read_ram #(.DATA_W(DW), .DEPTH(DP), .INIT_VAL(13)) u_rst_read_ram (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .re(re), .raddr(raddr), .rdata(rd_a));

    rst_read_ram #(.DATA_W(DW), .DEPTH(DP), .INIT_VAL(13), .RESETLESS(1'b1)) u_rl (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .re(re), .raddr(raddr), .rdata(rd_b));

    rst_read_ram #(.DATA_W(DW), .DEPTH(DP), .INIT_VAL(165), .ASYNC_RST(1'b1)) u_ar (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .re(re), .raddr(raddr), .rdata(rd_c));

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        // R1: power-up value on all variants
        check("R1 default", rd_a, INIT_A);
        check("R1 resetless", rd_b, INIT_A);
        check("R1 async", rd_c, INIT_C);
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R4 default idle", rd_a, INIT_A);

        // R10: write every address with re low; output untouched
        for (int a = 0; a < DP; a++) begin
            model[a] = DW'((a * 37 + 11) & 255);
            we = 1'b1; waddr = AW'(a); wdata = model[a];
            step();
            check("R10 default write hidden", rd_a, INIT_A);
            check("R10 async write hidden", rd_c, INIT_C);
        end
        we = 1'b0;

        // R3: read sweep
        for (int a = 0; a < DP; a++) begin
            re = 1'b1; raddr = AW'(a);
            step();
            check("R3 default read", rd_a, model[a]);
            check("R3 resetless read", rd_b, model[a]);
            check("R3 async read", rd_c, model[a]);
        end

        // R5: read-first on same-address collision, then R10 new data
        for (int a = 0; a < DP; a++) begin
            we = 1'b1; waddr = AW'(a); wdata = DW'((a * 91 + 200) & 255);
            re = 1'b1; raddr = AW'(a);
            step();
            check("R5 default read-first", rd_a, model[a]);
            check("R5 async read-first", rd_c, model[a]);
            model[a] = wdata;
        end
        we = 1'b0;
        for (int a = 0; a < DP; a++) begin
            re = 1'b1; raddr = AW'(a);
            step();
            check("R10 default new data", rd_a, model[a]);
        end

        // R4: hold with re low
        re = 1'b0;
        repeat (3) step();
        check("R4 default hold", rd_a, model[DP-1]);
        check("R4 resetless hold", rd_b, model[DP-1]);

        // R9 / R2 / R6 / R7: reset pulse with a read pending
        rst = 1'b1; re = 1'b1; raddr = AW'(2);
        #1;
        check("R9 async immediate", rd_c, INIT_C);
        check("R2 sync waits for edge", rd_a, model[DP-1]);
        step();
        check("R6 reset beats read", rd_a, INIT_A);
        check("R7 resetless reads on", rd_b, model[2]);
        check("R9 async held", rd_c, INIT_C);
        re = 1'b0;
        step();
        rst = 1'b0;
        step();
        check("R2 default init kept", rd_a, INIT_A);
        check("R7 resetless unchanged", rd_b, model[2]);
        check("R4 async init held", rd_c, INIT_C);

        // R8: array survived the reset
        re = 1'b1; raddr = AW'(5);
        step();
        check("R8 default contents", rd_a, model[5]);
        check("R8 resetless contents", rd_b, model[5]);
        check("R8 async contents", rd_c, model[5]);
        re = 1'b0;
        step();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule